// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This unit turns an abstract floating-point value into a correctly rounded IEEE single-precision word and raises overflow, underflow and inexact flags. The value arrives as three fields. The first is a sign. The second is a signed 16-bit biased exponent, held one below the true exponent. The third is a 32-bit significand whose binary point lies between bits 30 and 29, so its low 7 bits are rounding bits. A normalized significand has bit 30 set, and bit 31 is always zero. A 2-bit rounding mode and a 1-bit tininess mode come in alongside the value. An arithmetic stage that has already formed the exact sum, product or quotient uses the unit as its final step.

Every input is classified onto one of three named paths: PATH_NORMAL, PATH_OVERFLOW or PATH_TINY.
- The exponent is first screened with one unsigned compare against 0xFD. Values that fail the screen go to PATH_NORMAL.
- A large exponent, or exponent 0xFD with a rounding carry, goes to PATH_OVERFLOW. That path returns infinity or the largest finite value.
- A negative exponent goes to PATH_TINY. That path shifts the significand right with a sticky bit and produces a subnormal.

The result fields are combined by addition, so a carry out of the significand raises the exponent. The result is registered, and `out_valid` marks it one cycle after `in_valid`.

Top module: `sp_round_pack`

## Requirements
- R1: `rmode_i` is encoded 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity. The increment added to the significand is 0x40 for nearest-even and 0 for toward zero. For the two directed modes it is 0x7F when the mode rounds away from zero for the sign, and 0 otherwise.
- R2: `inx_o` is 1 whenever the final 7 rounding bits are nonzero, and also on overflow.
- R3: The overflow path is taken when the exponent, read as a signed value, is greater than 0xFD. It is also taken when the exponent equals 0xFD and significand plus increment has bit 31 set.
- R4: On overflow, `ovf_o` and `inx_o` are both 1. The result is sign|0x7F800000 when the increment is nonzero, and sign|0x7F7FFFFF when it is zero.
- R5: For a negative exponent, the value is tiny if any of three conditions holds:
  - `tiny_before_i` is 1;
  - the exponent is below -1;
  - significand plus increment is below 0x80000000.
- R6: For a negative exponent, the significand is shifted right by the negated exponent. Any 1 bits shifted out are ORed into bit 0. A shift of 31 or more leaves only that sticky bit. The exponent then becomes 0.
- R7: `unf_o` is 1 exactly when the value is tiny and the rounding bits after the shift are nonzero.
- R8: In nearest-even mode, when the rounding bits equal exactly 0x40, bit 0 of the rounded significand is cleared.
- R9: The result is (sign<<31) + (exponent<<23) + ((significand + increment)>>7). The integer bit and any rounding carry therefore add into the exponent field.
- R10: `out_valid` is 1 in the cycle after `in_valid` is 1. When `in_valid` is 0, `out_valid` falls and the result and flags hold their values.
- R11: After reset, `out_valid`, the result and all flags are 0.
- R12: When the rounded significand is zero, the exponent field is forced to 0, so the result is a signed zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | The input value is present this cycle |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | 16 | Signed biased exponent, one below the true exponent |
| sig_i | input | 32 | Significand with 7 low rounding bits |
| rmode_i | input | 2 | Rounding mode (see R1) |
| tiny_before_i | input | 1 | 1: tininess is detected before rounding, 0: after |
| out_valid | output | 1 | The result registers hold a new value |
| result_o | output | 32 | Packed single-precision word |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inx_o | output | 1 | Inexact flag |

## Verification
Random normalized significands are drawn with exponents across three ranges:
- the ordinary range, which exercises the increment and tie handling of every mode;
- the band 0xFD to 0xFF, which separates a rounding carry that overflows from one that does not;
- negative exponents down to -40, which separate sticky shifts with and without underflow.

Forced 0x40 rounding bits create exact ties in each mode. They tell nearest-even LSB clearing apart from the directed increments. Directed cases pin the remaining corners:
- exponent -1 with a carry, under both tininess settings;
- shifts large enough to keep only the sticky bit;
- a zero significand at a nonzero exponent;
- a rounding carry that moves the exponent field.

// File: rtl/sp_rp_pkg.sv
package sp_rp_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_DOWN      = 2'b10,
        RM_UP        = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        PATH_NORMAL   = 2'b00,
        PATH_OVERFLOW = 2'b01,
        PATH_TINY     = 2'b10
    } path_e;
endpackage

// File: rtl/sp_rp_incr.sv
module sp_rp_incr
    import sp_rp_pkg::*;
#(
    parameter int GRD_W = 7
) (
    input  logic [1:0]       rmode,
    input  logic             sign,
    output logic [GRD_W-1:0] inc
);
    localparam logic [GRD_W-1:0] HALF = GRD_W'(1) << (GRD_W - 1);
    localparam logic [GRD_W-1:0] FULL = '1;

    // R1: increment selection per mode and sign
    always_comb begin
        unique case (rmode_e'(rmode))
            RM_NEAR_EVEN: inc = HALF;
            RM_TO_ZERO:   inc = '0;
            RM_DOWN:      inc = sign ? FULL : '0;
            RM_UP:        inc = sign ? '0 : FULL;
            default:      inc = '0;
        endcase
    end
endmodule

// File: rtl/sp_rp_jam_shift.sv
module sp_rp_jam_shift #(
    parameter int W  = 32,
    parameter int AW = 16
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic lost;

    // R6: right shift whose shifted-out ones collapse into bit 0
    always_comb begin
        lost = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (int'(amt) > i) lost = lost | din[i];
        end
        if (int'(amt) >= W - 1) begin
            dout = {{(W-1){1'b0}}, |din};
        end else begin
            dout = (din >> amt) | {{(W-1){1'b0}}, lost};
        end
    end
endmodule

// File: rtl/sp_rp_pack.sv
module sp_rp_pack #(
    parameter int SIG_W  = 32,
    parameter int GRD_W  = 7,
    parameter int EXP_W  = 16,
    parameter int FRAC_W = 23,
    parameter int WORD_W = 32
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_eff,
    input  logic [SIG_W-1:0]  sig_eff,
    input  logic [GRD_W-1:0]  inc,
    input  logic              near_even,
    output logic [WORD_W-1:0] word,
    output logic              inexact
);
    localparam logic [GRD_W-1:0] TIE = GRD_W'(1) << (GRD_W - 1);

    logic [SIG_W-1:0]  q;
    logic [EXP_W-1:0]  exp_fin;
    logic              tie;

    always_comb begin
        tie     = (sig_eff[GRD_W-1:0] == TIE);
        inexact = |sig_eff[GRD_W-1:0];                                   // R2
        q       = (sig_eff + SIG_W'(inc)) >> GRD_W;
        if (near_even && tie) q[0] = 1'b0;                               // R8
        exp_fin = (q == '0) ? '0 : exp_eff;                              // R12
        // R9: fields summed so a carry reaches the exponent
        word    = ({sign, {(WORD_W-1){1'b0}}})
                + (WORD_W'(exp_fin) << FRAC_W)
                + WORD_W'(q);
    end
endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
    import sp_rp_pkg::*;
#(
    parameter int EXP_W  = 16,
    parameter int EFLD_W = 8,
    parameter int FRAC_W = 23,
    parameter int GRD_W  = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          sign_i,
    input  logic [EXP_W-1:0]              exp_i,
    input  logic [2+FRAC_W+GRD_W-1:0]     sig_i,
    input  logic [1:0]                    rmode_i,
    input  logic                          tiny_before_i,
    output logic                          out_valid,
    output logic [1+EFLD_W+FRAC_W-1:0]    result_o,
    output logic                          ovf_o,
    output logic                          unf_o,
    output logic                          inx_o
);
    localparam int SIG_W   = 2 + FRAC_W + GRD_W;
    localparam int WORD_W  = 1 + EFLD_W + FRAC_W;
    localparam int OVF_EXP = (1 << EFLD_W) - 3;
    localparam logic [EXP_W-1:0] OVF_E = EXP_W'(OVF_EXP);
    localparam logic [WORD_W-2:0] MAG_INF = {{EFLD_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-2:0] MAG_MAX = {{(EFLD_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

    logic [GRD_W-1:0]  inc;
    logic [SIG_W-1:0]  shifted;
    logic [SIG_W-1:0]  sig_eff;
    logic [EXP_W-1:0]  exp_eff;
    logic [EXP_W-1:0]  amt;
    logic [WORD_W-1:0] word_pk;
    logic              inx_pk;
    logic              special, neg, carry, tiny;
    path_e             path;

    logic [WORD_W-1:0] res_d;
    logic              ovf_d, unf_d, inx_d;

    sp_rp_incr #(.GRD_W(GRD_W)) u_incr (
        .rmode (rmode_i),
        .sign  (sign_i),
        .inc   (inc)
    );

    sp_rp_jam_shift #(.W(SIG_W), .AW(EXP_W)) u_jam (
        .din  (sig_i),
        .amt  (amt),
        .dout (shifted)
    );

    sp_rp_pack #(
        .SIG_W(SIG_W), .GRD_W(GRD_W), .EXP_W(EXP_W),
        .FRAC_W(FRAC_W), .WORD_W(WORD_W)
    ) u_pack (
        .sign      (sign_i),
        .exp_eff   (exp_eff),
        .sig_eff   (sig_eff),
        .inc       (inc),
        .near_even (rmode_e'(rmode_i) == RM_NEAR_EVEN),
        .word      (word_pk),
        .inexact   (inx_pk)
    );

    // Classification: one unsigned compare screens both ends (R3)
    always_comb begin
        special = (exp_i >= OVF_E);
        neg     = exp_i[EXP_W-1];
        carry   = |((sig_i + SIG_W'(inc)) >> (SIG_W - 1));
        amt     = -exp_i;
        // R5: below -1 means not all ones when negative
        tiny    = tiny_before_i || (exp_i != '1) || !carry;
        if (special && !neg && ((exp_i != OVF_E) || carry))
            path = PATH_OVERFLOW;
        else if (special && neg)
            path = PATH_TINY;
        else
            path = PATH_NORMAL;
    end

    always_comb begin
        sig_eff = sig_i;
        exp_eff = exp_i;
        res_d   = word_pk;
        ovf_d   = 1'b0;
        unf_d   = 1'b0;
        inx_d   = inx_pk;
        unique case (path)
            PATH_NORMAL: begin
                sig_eff = sig_i;
                exp_eff = exp_i;
            end
            PATH_TINY: begin
                sig_eff = shifted;                                      // R6
                exp_eff = '0;
                unf_d   = tiny && inx_pk;                               // R7
            end
            PATH_OVERFLOW: begin
                res_d = {sign_i, (inc == '0) ? MAG_MAX : MAG_INF};      // R4
                ovf_d = 1'b1;
                inx_d = 1'b1;
            end
            default: begin
                sig_eff = sig_i;
            end
        endcase
    end

    // R10, R11: registered result with valid strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result_o  <= '0;
            ovf_o     <= 1'b0;
            unf_o     <= 1'b0;
            inx_o     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result_o <= res_d;
                ovf_o    <= ovf_d;
                unf_o    <= unf_d;
                inx_o    <= inx_d;
            end
        end
    end

    p_ovf_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> inx_o);

    p_ovf_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (result_o[WORD_W-2:0] == MAG_INF || result_o[WORD_W-2:0] == MAG_MAX));

    p_unf_inexact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> inx_o);

    p_sticky_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && path == PATH_TINY && sig_i != '0) |-> (sig_eff != '0));

    p_valid_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result_o)));
endmodule

// File: tb/test_sp_round_pack.sv
`timescale 1ns/1ps
module test_sp_round_pack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sign_i = 1'b0;
    logic [15:0] exp_i = '0;
    logic [31:0] sig_i = '0;
    logic [1:0]  rmode_i = '0;
    logic        tiny_before_i = 1'b0;
    logic        out_valid;
    logic [31:0] result_o;
    logic        ovf_o, unf_o, inx_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sp_round_pack i_sp_round_pack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sign_i(sign_i),
        .exp_i(exp_i), .sig_i(sig_i), .rmode_i(rmode_i),
        .tiny_before_i(tiny_before_i), .out_valid(out_valid),
        .result_o(result_o), .ovf_o(ovf_o), .unf_o(unf_o), .inx_o(inx_o)
    );

    // Model from the requirements: {ovf, unf, inx, word}
    function automatic logic [34:0] ref_model(input logic s, input logic [15:0] e,
                                              input logic [31:0] g, input logic [1:0] m,
                                              input logic tb);
        longint ex, n;
        longint unsigned inc, sg, rb, q, w;
        bit tiny, unf;
        ex = longint'($signed(e));
        case (m)
            2'b00:   inc = 64;
            2'b01:   inc = 0;
            2'b10:   inc = s ? 127 : 0;
            default: inc = s ? 0 : 127;
        endcase
        if (ex > 253 || (ex == 253 && (((g + inc) >> 31) & 1) == 1))
            return {3'b101, s, (inc == 0) ? 31'h7F7FFFFF : 31'h7F800000};
        sg = longint'(g);
        unf = 0;
        if (ex < 0) begin
            tiny = tb || ex < -1 || (sg + inc) < 64'h80000000;
            n = -ex;
            if (n > 40) n = 40;
            for (longint k = 0; k < n; k++) sg = (sg >> 1) | (sg & 1);
            ex = 0;
            unf = tiny && ((sg & 127) != 0);
        end
        rb = sg & 127;
        q = (sg + inc) >> 7;
        if (m == 2'b00 && rb == 64) q = q & ~64'd1;
        if (q == 0) ex = 0;
        w = (longint'(s) << 31) + (ex << 23) + q;
        return {1'b0, unf, rb != 0, w[31:0]};
    endfunction

    task automatic check(input string tag, input logic [34:0] got, input logic [34:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got ovf/unf/inx=%b word=%h, expected ovf/unf/inx=%b word=%h",
                     tag, got[34:32], got[31:0], want[34:32], want[31:0]);
        end
    endtask

    task automatic run_vec(input string tag, input logic s, input logic [15:0] e,
                           input logic [31:0] g, input logic [1:0] m, input logic tb);
        logic [34:0] want;
        want = ref_model(s, e, g, m, tb);
        @(negedge clk);
        sign_i = s; exp_i = e; sig_i = g; rmode_i = m; tiny_before_i = tb;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {3'b000, 31'd0, out_valid}, {3'b000, 31'd0, 1'b1});
        check(tag, {ovf_o, unf_o, inx_o, result_o}, want);
    endtask

    initial begin
        logic [31:0] held;
        int unused_seed;
        unused_seed = $urandom(32'h5EED1234);
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset", {ovf_o, unf_o, inx_o, result_o}, 35'd0);
        check("R11 reset valid", {34'd0, out_valid}, 35'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 / R1 ties: 1.0 with tie, and odd LSB with tie
        run_vec("R8 tie even", 0, 16'h007E, 32'h40000040, 2'b00, 0);
        run_vec("R8 tie odd", 0, 16'h007E, 32'h400000C0, 2'b00, 0);
        run_vec("R1 tie toward zero", 0, 16'h007E, 32'h400000C0, 2'b01, 0);
        run_vec("R1 tie down neg", 1, 16'h007E, 32'h40000040, 2'b10, 0);
        run_vec("R1 tie up pos", 0, 16'h007E, 32'h40000040, 2'b11, 0);
        run_vec("R1 up neg", 1, 16'h007E, 32'h4000007F, 2'b11, 0);
        run_vec("R2 exact", 0, 16'h0080, 32'h40000000, 2'b00, 0);
        // R9: carry moves the exponent; expected 0x40000000
        check("R9 literal", ref_model(0, 16'h007E, 32'h7FFFFFC0, 2'b00, 0), {3'b001, 32'h40000000});
        run_vec("R9 carry", 0, 16'h007E, 32'h7FFFFFC0, 2'b00, 0);
        // R3 / R4
        run_vec("R3 0xFD carry", 0, 16'h00FD, 32'h7FFFFFC0, 2'b00, 0);
        run_vec("R3 0xFD no carry", 0, 16'h00FD, 32'h7FFFFF80, 2'b00, 0);
        run_vec("R3 0xFE", 0, 16'h00FE, 32'h40000000, 2'b00, 0);
        check("R4 literal", ref_model(0, 16'h00FE, 32'h40000000, 2'b01, 0), {3'b101, 32'h7F7FFFFF});
        run_vec("R4 toward zero", 0, 16'h00FE, 32'h40000000, 2'b01, 0);
        run_vec("R4 up neg", 1, 16'h0200, 32'h40000000, 2'b11, 0);
        run_vec("R4 down neg", 1, 16'h0200, 32'h40000000, 2'b10, 0);
        // R5 / R7: exponent -1 with carry, after vs before rounding
        run_vec("R5 after not tiny", 0, 16'hFFFF, 32'h7FFFFFC0, 2'b00, 0);
        run_vec("R5 before tiny", 0, 16'hFFFF, 32'h7FFFFFC0, 2'b00, 1);
        run_vec("R7 exact subnormal", 0, 16'hFFFD, 32'h40000000, 2'b00, 0);
        // R6 / R12: only sticky remains
        run_vec("R6 sticky near", 1, 16'hFFD8, 32'h40000001, 2'b00, 0);
        run_vec("R6 sticky up", 0, 16'hFFD8, 32'h40000001, 2'b11, 0);
        run_vec("R6 huge shift", 0, 16'h8000, 32'h40000000, 2'b11, 1);
        run_vec("R12 zero sig", 0, 16'h0005, 32'h00000000, 2'b00, 0);

        // R10: hold while idle
        run_vec("R10 load", 0, 16'h0081, 32'h50000000, 2'b00, 0);
        held = result_o;
        @(negedge clk);
        exp_i = 16'h0010; sig_i = 32'h7FFFFFFF; sign_i = 1'b1;
        @(negedge clk);
        check("R10 hold", {3'b000, result_o}, {3'b000, held});
        check("R10 idle valid", {34'd0, out_valid}, 35'd0);

        // Random mix: R1 R2 R3 R5 R6 R7 R8 R9
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] e;
            logic [31:0] g;
            case ($urandom % 4)
                0: e = 16'($urandom_range(1, 252));
                1: e = 16'(253 + ($urandom % 3));
                2: e = 16'(-int'($urandom_range(1, 40)));
                default: e = ($urandom % 2) ? 16'h0000 : 16'(254 + ($urandom % 200));
            endcase
            g = {2'b01, 30'($urandom)};
            if ($urandom % 8 == 0) g = {1'b0, 31'($urandom)} >> ($urandom % 8);
            if ($urandom % 4 == 0) g[6:0] = 7'h40;
            run_vec("R1-mix random", 1'($urandom), e, g, 2'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule